// File: doc/BRIEF.md
# Floating-Point Sign Manipulation Execute Unit

This unit is a single-issue execute stage for the four floating-point sign and copy operations: negate, absolute value, negative absolute value and register move. Each cycle with `valid_i` high it takes one 32-bit instruction word, splits out the operand fields, and reads one source from a 32 x 64-bit floating-point register file. It then changes only the sign bit, or copies the value as it is, and writes the result to the destination register. The operations do no arithmetic. They never round, never raise an exception flag and pass NaN payloads through untouched.

When the record bit of the instruction is set, the unit copies four summary bits of the floating-point status word into condition-register field 1. It does not compare the result. The register file and the condition register each have a preload port, used by the surrounding pipeline or by a bench to set up state. The result, its destination index and an illegal-instruction flag come out one cycle after issue, together with `done_o`.

Top module: `fp_sign_unit`

## Requirements
- R1: Fields are decoded with bit 0 as the instruction MSB: primary opcode = bits 0..5 (`instr_i[31:26]`), destination = bits 6..10 (`instr_i[25:21]`), source A = bits 11..15, source B = bits 16..20 (`instr_i[15:11]`), extended opcode = bits 21..30 (`instr_i[10:1]`), record flag = bit 31 (`instr_i[0]`). Primary opcode 63 with extended opcode 40 is negate, so word 0xFC000050 negates FR0 into FR0 with no record.
- R2: Negate writes source B with bit 63 (the sign) inverted and bits 62..0 copied. This holds for zeros (+0 <-> -0), infinities and NaNs, signalling NaNs included, with the payload unchanged.
- R3: Extended opcode 264 (absolute value) writes source B with bit 63 cleared and the other bits copied.
- R4: Extended opcode 136 (negative absolute value) writes source B with bit 63 set and the other bits copied.
- R5: Extended opcode 72 (move) writes the 64-bit source B pattern unchanged.
- R6: The source A field has no effect on the result. Only the register named by the source B field is read.
- R7: For a legal instruction with record flag 1, CR field 1 (`cr_o[27:24]`) takes `fpscr_i[31:28]` as sampled in the issue cycle. The order is summary exception, enabled exception, invalid operation, overflow, with `fpscr_i[31]` going to `cr_o[27]`. All other CR bits are kept. With record flag 0 the CR is not changed.
- R8: Any other primary or extended opcode asserts `illegal_o` with `done_o`. It writes no floating-point register and does not update CR field 1.
- R9: Every cycle with `valid_i` high is followed by exactly one cycle with `done_o` high, carrying `result_o` and `dest_o`. The written value is visible to an instruction issued in the next cycle.
- R10: A read of a register that is being written in the same cycle returns the old value. A register preload in a cycle where a legal instruction writes is discarded.
- R11: A CR preload and a record-form update in the same cycle both take effect: field 1 takes the status bits and the other 28 bits take the preload data.
- R12: After reset all registers, `cr_o`, `result_o` and `done_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Issue strobe for `instr_i` |
| instr_i | input | 32 | Instruction word |
| fpscr_i | input | 32 | Current floating-point status word, MSB = bit 0 |
| rf_ld_en_i | input | 1 | Register preload enable |
| rf_ld_addr_i | input | 5 | Register preload index |
| rf_ld_data_i | input | 64 | Register preload value |
| cr_ld_en_i | input | 1 | Condition-register preload enable |
| cr_ld_data_i | input | 32 | Condition-register preload value |
| done_o | output | 1 | Instruction completed in the previous cycle |
| illegal_o | output | 1 | Completed instruction was not recognised |
| result_o | output | 64 | Value written (zero when illegal) |
| dest_o | output | 5 | Destination index of the completed instruction |
| cr_o | output | 32 | Condition register |

## Verification
Two paths can act in the same cycle. The first pair is the instruction writeback and a preload of the register file. The bench issues an instruction together with a preload, aimed at the register being read and at a different register. It then confirms through later move instructions that the source was read old and that the preload was discarded. The second pair is the record-form CR update and a CR preload. They are driven in one cycle with opposite bit patterns, and the scoreboard expects field 1 from the status word and every other bit from the preload.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam int unsigned INSTR_W = 32;
  localparam int unsigned PRIM_W  = 6;
  localparam int unsigned XO_W    = 10;
  localparam int unsigned RIDX_W  = 5;

  localparam logic [PRIM_W-1:0] PRIM_FP = 6'd63;
  localparam logic [XO_W-1:0]   XO_NEG  = 10'd40;
  localparam logic [XO_W-1:0]   XO_ABS  = 10'd264;
  localparam logic [XO_W-1:0]   XO_NABS = 10'd136;
  localparam logic [XO_W-1:0]   XO_MOVE = 10'd72;

  typedef enum logic [1:0] {
    SGN_KEEP = 2'd0,
    SGN_FLIP = 2'd1,
    SGN_CLR  = 2'd2,
    SGN_SET  = 2'd3
  } sgn_op_e;

  typedef struct packed {
    logic [RIDX_W-1:0] frt;
    logic [RIDX_W-1:0] fra;
    logic [RIDX_W-1:0] frb;
    logic              rec;
    logic              legal;
    sgn_op_e           op;
  } dec_t;
endpackage

// File: rtl/fps_decode.sv
module fps_decode
  import fps_pkg::*;
(
  input  logic [INSTR_W-1:0] instr_i,
  output dec_t               dec_o
);
  // IBM numbering: bit 0 is the MSB
  logic [PRIM_W-1:0] prim;
  logic [XO_W-1:0]   xo;

  assign prim = instr_i[31:26];
  assign xo   = instr_i[10:1];

  always_comb begin
    dec_o.frt   = instr_i[25:21];
    dec_o.fra   = instr_i[20:16];
    dec_o.frb   = instr_i[15:11];
    dec_o.rec   = instr_i[0];
    dec_o.legal = 1'b0;
    dec_o.op    = SGN_KEEP;
    if (prim == PRIM_FP) begin
      unique case (xo)
        XO_NEG:  begin dec_o.legal = 1'b1; dec_o.op = SGN_FLIP; end
        XO_ABS:  begin dec_o.legal = 1'b1; dec_o.op = SGN_CLR;  end
        XO_NABS: begin dec_o.legal = 1'b1; dec_o.op = SGN_SET;  end
        XO_MOVE: begin dec_o.legal = 1'b1; dec_o.op = SGN_KEEP; end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/fps_regfile.sv
module fps_regfile #(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 64,
  localparam int unsigned AW  = $clog2(NREG)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) mem[i] <= '0;
    end else if (we_i) begin
      mem[waddr_i] <= wdata_i;
    end
  end

  // read is combinational: same-cycle write is seen only after the edge
  assign rdata_o = mem[raddr_i];

  // R9
  wr_lands_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(we_i) |-> mem[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/fps_sign_alu.sv
module fps_sign_alu
  import fps_pkg::*;
#(
  parameter int unsigned DW = 64
) (
  input  sgn_op_e       op_i,
  input  logic [DW-1:0] src_i,
  output logic [DW-1:0] res_o
);
  logic sgn;

  always_comb begin
    unique case (op_i)
      SGN_FLIP: sgn = ~src_i[DW-1];
      SGN_CLR:  sgn = 1'b0;
      SGN_SET:  sgn = 1'b1;
      default:  sgn = src_i[DW-1];
    endcase
  end

  assign res_o = {sgn, src_i[DW-2:0]};
endmodule

// File: rtl/fp_sign_unit.sv
module fp_sign_unit
  import fps_pkg::*;
#(
  parameter int unsigned NREG = 32,
  parameter int unsigned DW   = 64,
  parameter int unsigned CRW  = 32,
  parameter int unsigned FSW  = 32,
  parameter int unsigned CR_FIELD = 1,
  localparam int unsigned AW     = $clog2(NREG),
  localparam int unsigned CF_HI  = CRW - 1 - 4 * CR_FIELD,
  localparam int unsigned CF_LO  = CF_HI - 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               valid_i,
  input  logic [INSTR_W-1:0] instr_i,
  input  logic [FSW-1:0]     fpscr_i,
  input  logic               rf_ld_en_i,
  input  logic [AW-1:0]      rf_ld_addr_i,
  input  logic [DW-1:0]      rf_ld_data_i,
  input  logic               cr_ld_en_i,
  input  logic [CRW-1:0]     cr_ld_data_i,
  output logic               done_o,
  output logic               illegal_o,
  output logic [DW-1:0]      result_o,
  output logic [AW-1:0]      dest_o,
  output logic [CRW-1:0]     cr_o
);
  dec_t          dec;
  logic [DW-1:0] src_data;
  logic [DW-1:0] alu_res;
  logic          exe_wr;
  logic          rf_we;
  logic [AW-1:0] rf_wa;
  logic [DW-1:0] rf_wd;
  logic [CRW-1:0] cr_nxt;
  logic          rec_q;

  fps_decode u_dec (
    .instr_i (instr_i),
    .dec_o   (dec)
  );

  fps_regfile #(.NREG(NREG), .DW(DW)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (rf_we),
    .waddr_i (rf_wa),
    .wdata_i (rf_wd),
    .raddr_i (dec.frb[AW-1:0]),
    .rdata_o (src_data)
  );

  fps_sign_alu #(.DW(DW)) u_alu (
    .op_i  (dec.op),
    .src_i (src_data),
    .res_o (alu_res)
  );

  assign exe_wr = valid_i & dec.legal;

  // single write port: instruction writeback owns it, preload yields
  assign rf_we = exe_wr | rf_ld_en_i;
  assign rf_wa = exe_wr ? dec.frt[AW-1:0] : rf_ld_addr_i;
  assign rf_wd = exe_wr ? alu_res : rf_ld_data_i;

  always_comb begin
    cr_nxt = cr_ld_en_i ? cr_ld_data_i : cr_o;
    if (exe_wr && dec.rec) cr_nxt[CF_HI:CF_LO] = fpscr_i[FSW-1:FSW-4];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_o    <= 1'b0;
      illegal_o <= 1'b0;
      result_o  <= '0;
      dest_o    <= '0;
      rec_q     <= 1'b0;
      cr_o      <= '0;
    end else begin
      done_o    <= valid_i;
      cr_o      <= cr_nxt;
      if (valid_i) begin
        illegal_o <= ~dec.legal;
        result_o  <= dec.legal ? alu_res : '0;
        dest_o    <= dec.frt[AW-1:0];
        rec_q     <= dec.rec;
      end
    end
  end

  // R9
  done_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> done_o);
  // R9
  no_spurious_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !done_o);
  // R2
  body_kept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && dec.legal) |=> result_o[DW-2:0] == $past(src_data[DW-2:0]));
  // R7
  cr1_copy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !illegal_o && rec_q) |-> cr_o[CF_HI:CF_LO] == $past(fpscr_i[FSW-1:FSW-4]));
  // R7
  cr_rest_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(cr_ld_en_i) |-> (cr_o[CRW-1:CF_HI+1] == $past(cr_o[CRW-1:CF_HI+1]) &&
                            cr_o[CF_LO-1:0] == $past(cr_o[CF_LO-1:0])));
  // R8
  illegal_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && illegal_o && !$past(cr_ld_en_i)) |-> $stable(cr_o));
endmodule

// File: tb/fp_sign_unit_tb.sv
`timescale 1ns/1ps
module fp_sign_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        valid = 1'b0;
  logic [31:0] instr = '0;
  logic [31:0] fpscr = '0;
  logic        rf_ld = 1'b0;
  logic [4:0]  rf_la = '0;
  logic [63:0] rf_ld_d = '0;
  logic        cr_ld = 1'b0;
  logic [31:0] cr_ld_d = '0;
  logic        done, illegal;
  logic [63:0] result;
  logic [4:0]  dest;
  logic [31:0] cr;

  int vectors = 0;
  int errors = 0;

  always #4 clk = ~clk;

  fp_sign_unit u_dut (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .instr_i(instr), .fpscr_i(fpscr),
    .rf_ld_en_i(rf_ld), .rf_ld_addr_i(rf_la), .rf_ld_data_i(rf_ld_d),
    .cr_ld_en_i(cr_ld), .cr_ld_data_i(cr_ld_d),
    .done_o(done), .illegal_o(illegal), .result_o(result), .dest_o(dest), .cr_o(cr)
  );

  typedef struct {
    logic [63:0] res;
    logic [4:0]  dst;
    logic        ill;
    logic [31:0] crv;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  logic [63:0] rf_m [32];
  logic [31:0] cr_m;

  function automatic logic [31:0] enc(input int prim, input int rt, input int ra,
                                      input int rb, input int xo, input bit rc);
    return {prim[5:0], rt[4:0], ra[4:0], rb[4:0], xo[9:0], rc};
  endfunction

  // driver: one call per cycle, inputs change at the falling edge
  task automatic drive(input bit v, input logic [31:0] ins, input logic [31:0] fps,
                       input bit lde, input logic [4:0] la, input logic [63:0] ld,
                       input bit cre, input logic [31:0] crd, input string tag);
    logic [5:0]  p;
    logic [9:0]  xo;
    logic [63:0] s, r;
    bit          legal;
    exp_t        e;
    @(negedge clk);
    valid = v; instr = ins; fpscr = fps;
    rf_ld = lde; rf_la = la; rf_ld_d = ld;
    cr_ld = cre; cr_ld_d = crd;
    p = ins[31:26]; xo = ins[10:1];
    s = rf_m[ins[15:11]];
    legal = (p == 6'd63) && (xo == 10'd40 || xo == 10'd264 || xo == 10'd136 || xo == 10'd72);
    case (xo)
      10'd40:  r = {~s[63], s[62:0]};
      10'd264: r = {1'b0, s[62:0]};
      10'd136: r = {1'b1, s[62:0]};
      default: r = s;
    endcase
    if (cre) cr_m = crd;
    if (v && legal && ins[0]) cr_m[27:24] = fps[31:28];
    if (v) begin
      e.res = r; e.dst = ins[25:21]; e.ill = !legal; e.crv = cr_m; e.tag = tag;
      sb.push_back(e);
    end
    if (v && legal) rf_m[ins[25:21]] = r;
    else if (lde) rf_m[la] = ld;
  endtask

  task automatic exec(input logic [31:0] ins, input logic [31:0] fps, input string tag);
    drive(1'b1, ins, fps, 1'b0, 5'd0, 64'd0, 1'b0, 32'd0, tag);
  endtask

  task automatic load(input int a, input logic [63:0] d);
    drive(1'b0, 32'd0, 32'd0, 1'b1, a[4:0], d, 1'b0, 32'd0, "load");
  endtask

  task automatic idle();
    drive(1'b0, 32'd0, 32'd0, 1'b0, 5'd0, 64'd0, 1'b0, 32'd0, "idle");
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        vectors++; errors++;
        $display("FAIL R9 done without issue: actual done=1 expected done=0");
      end else begin
        exp_t e;
        bit bad;
        e = sb.pop_front();
        vectors++;
        bad = (illegal !== e.ill) || (dest !== e.dst) || (cr !== e.crv) ||
              (!e.ill && result !== e.res);
        if (bad) begin
          errors++;
          $display("FAIL %s: actual res=%h dst=%0d ill=%0b cr=%h expected res=%h dst=%0d ill=%0b cr=%h",
                   e.tag, result, dest, illegal, cr, e.res, e.dst, e.ill, e.crv);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R9 watchdog expired: actual hung expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) rf_m[i] = '0;
    cr_m = '0;
    repeat (3) @(negedge clk);
    // R12: reset state
    vectors++;
    if (done !== 1'b0 || cr !== 32'd0 || result !== 64'd0) begin
      errors++;
      $display("FAIL R12 reset: actual done=%0b cr=%h res=%h expected 0 0 0", done, cr, result);
    end
    rst_n = 1'b1;

    // R12: registers read back as zero after reset
    exec(enc(63, 20, 0, 31, 72, 0), 32'd0, "R12 reg zero after reset");

    load(1, 64'h3FF0_0000_0000_0000);
    load(2, 64'h8000_0000_0000_0000);
    load(3, 64'h0000_0000_0000_0000);
    load(4, 64'h7FF0_0000_0000_0000);
    load(5, 64'h7FF4_0000_0000_0001);
    load(6, 64'hFFF8_0000_0000_0123);
    load(7, 64'hDEAD_BEEF_0BAD_F00D);

    // R1: canonical word 0xFC000050 negates FR0
    exec(32'hFC00_0050, 32'd0, "R1 word FC000050");
    // R2: negate across special values
    exec(enc(63, 8, 0, 1, 40, 0), 32'd0, "R2 neg 1.0");
    exec(enc(63, 9, 0, 2, 40, 0), 32'd0, "R2 neg -0");
    exec(enc(63, 10, 0, 3, 40, 0), 32'd0, "R2 neg +0");
    exec(enc(63, 11, 0, 4, 40, 0), 32'd0, "R2 neg +inf");
    exec(enc(63, 12, 0, 5, 40, 0), 32'd0, "R2 neg sNaN");
    exec(enc(63, 13, 0, 6, 40, 0), 32'd0, "R2 neg -qNaN");
    // R3 / R4 / R5
    exec(enc(63, 14, 0, 6, 264, 0), 32'd0, "R3 abs -qNaN");
    exec(enc(63, 15, 0, 1, 264, 0), 32'd0, "R3 abs positive");
    exec(enc(63, 16, 0, 1, 136, 0), 32'd0, "R4 nabs positive");
    exec(enc(63, 17, 0, 2, 136, 0), 32'd0, "R4 nabs -0");
    exec(enc(63, 18, 0, 7, 72, 0), 32'd0, "R5 move pattern");
    // R6: A field names a different register, must not matter
    exec(enc(63, 19, 7, 1, 40, 0), 32'd0, "R6 A field ignored");
    exec(enc(63, 19, 31, 5, 72, 0), 32'd0, "R6 A field ignored move");
    // R9: back-to-back dependent chain
    exec(enc(63, 21, 0, 1, 40, 0), 32'd0, "R9 chain first");
    exec(enc(63, 22, 0, 21, 40, 0), 32'd0, "R9 chain sees prior write");
    idle();

    // R7: record form, CR preset to ones
    drive(1'b0, 32'd0, 32'd0, 1'b0, 5'd0, 64'd0, 1'b1, 32'hFFFF_FFFF, "crload");
    exec(enc(63, 23, 0, 1, 40, 1), 32'hA000_0000, "R7 record 1010");
    exec(enc(63, 23, 0, 1, 264, 1), 32'h5FFF_FFFF, "R7 record 0101");
    exec(enc(63, 23, 0, 1, 136, 0), 32'hF000_0000, "R7 no record keeps CR");
    // R8: illegal opcodes
    exec(enc(31, 24, 0, 1, 40, 0), 32'd0, "R8 bad primary");
    exec(enc(63, 24, 0, 1, 41, 1), 32'hF000_0000, "R8 bad xo record");
    exec(enc(63, 25, 0, 24, 72, 0), 32'd0, "R8 dest untouched");
    // R10: read of register written same cycle gives old value
    exec(enc(63, 26, 0, 1, 72, 0), 32'd0, "R10 setup");
    exec(enc(63, 26, 0, 26, 40, 0), 32'd0, "R10 self read old");
    // R10: preload discarded under a legal write
    drive(1'b1, enc(63, 27, 0, 2, 72, 0), 32'd0, 1'b1, 5'd28, 64'h1234_5678_9ABC_DEF0,
          1'b0, 32'd0, "R10 collide move");
    exec(enc(63, 29, 0, 28, 72, 0), 32'd0, "R10 preload discarded");
    // preload with illegal instruction lands
    drive(1'b1, enc(0, 27, 0, 2, 72, 0), 32'd0, 1'b1, 5'd28, 64'h0F0F_0F0F_0F0F_0F0F,
          1'b0, 32'd0, "R8 illegal with preload");
    exec(enc(63, 29, 0, 28, 72, 0), 32'd0, "R10 preload lands when idle port");
    // R11: CR preload and record update in one cycle
    drive(1'b1, enc(63, 30, 0, 3, 40, 1), 32'hF000_0000, 1'b0, 5'd0, 64'd0,
          1'b1, 32'h0000_0000, "R11 cr collide A");
    drive(1'b1, enc(63, 30, 0, 3, 40, 1), 32'h0000_0000, 1'b0, 5'd0, 64'd0,
          1'b1, 32'hFFFF_FFFF, "R11 cr collide B");
    // R2: double negate restores
    exec(enc(63, 31, 0, 5, 40, 0), 32'd0, "R2 neg once");
    exec(enc(63, 31, 0, 31, 40, 0), 32'd0, "R2 neg twice");
    idle();
    idle();
    idle();

    vectors++;
    if (sb.size() != 0) begin
      errors++;
      $display("FAIL R9 missing completions: actual %0d pending expected 0", sb.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule